// File: doc/BRIEF.md
# Channel interrupt flag controller

This block keeps an event flag and a request-enable bit for each of 16 timer channels and combines them into one interrupt request toward a host processor. Each channel's function logic raises its flag with a one-cycle set pulse. The host sees both registers over a small 16-bit register bus that has byte lanes.

A flag cannot be cleared by a single blind write. The host first reads the status register. The block records which flags read back as 1 at that moment. A later write of 0 clears only those recorded bits. A flag that was raised after the read survives the write, so no event is lost. A 3-bit request level input gates the request output: a level of zero holds the request low.

Top module: `chan_irq_ctrl`

## Requirements
- R1: After reset all status flags and all enable bits read as 0, and irq_o is low.
- R2: A high ch_set_i[n] in a cycle sets status flag n at that clock edge. The flag is visible on a status read in the following cycle.
- R3: irq_o is a register. It goes high one clock after some channel has both its flag and its enable set while irq_lvl_i is nonzero. It stays low in the cycle in which that condition first becomes true.
- R4: While irq_lvl_i is 0, irq_o is low from the next clock on, whatever the flags and enables hold.
- R5: A channel whose enable bit is 0 does not cause irq_o, even when its flag is set.
- R6: A status write (bus_addr_i=1) clears flag n only if bit n of the write data is 0 and the most recent status read returned flag n as 1. A set flag that was not seen as set by that read is left set.
- R7: Writing 1 to any status bit has no effect, so the host can never set a flag.
- R8: If a set pulse for a channel coincides with a valid clearing write of that channel's flag, the flag remains set.
- R9: Status writes honour byte lanes. bus_be_i[0] covers bits 7:0 and bus_be_i[1] covers bits 15:8, and a lane whose enable is 0 is left untouched.
- R10: The enable register (bus_addr_i=0) changes only on a write with both byte enables high (bus_be_i=2'b11). A write with a partial byte enable leaves it unchanged.
- R11: bus_rdata_o shows the enable register when bus_addr_i=0 and the status flags when bus_addr_i=1.
- R12: A status write uses up the read record for each lane it writes. After such a write, a flag set again in a written lane needs a fresh status read before a 0 write can clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ch_set_i | input | 16 | Per-channel flag set pulses |
| bus_req_i | input | 1 | Register access valid |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 1 | 0 = enable register, 1 = status register |
| bus_be_i | input | 2 | Byte enables, bit 0 for the low byte |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data of the addressed register (combinational) |
| irq_lvl_i | input | 3 | Request level; zero masks the request |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Several rules are checked by assertions on every cycle. A flag can only rise when its set pulse was present. A flag can only fall when it had been recorded by a status read. A set pulse always leaves its flag set. A partial write never changes the enable register. The request follows the flag, enable and level terms one clock later.

Other rules depend on order and need the bench's scenarios:
- The read-then-write clearing protocol, including a flag raised between the read and the write.
- The read record being used up by a write.
- Byte-lane independence.
- Writes of all ones being ignored.

// File: rtl/cirq_pkg.sv
package cirq_pkg;
  localparam int unsigned CIRQ_NCH   = 16;
  localparam int unsigned CIRQ_LVL_W = 3;
  localparam int unsigned CIRQ_LANE  = 8;

  typedef enum logic {
    SEL_ENA  = 1'b0,
    SEL_FLAG = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/cirq_enable_reg.sv
module cirq_enable_reg #(
  parameter int unsigned NCH   = cirq_pkg::CIRQ_NCH,
  localparam int unsigned LANES = NCH / cirq_pkg::CIRQ_LANE
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [LANES-1:0] be_i,
  input  logic [NCH-1:0]   wdata_i,
  output logic [NCH-1:0]   ena_o
);
  logic [NCH-1:0] ena_q;
  logic           full_wr;

  assign full_wr = wr_i && (&be_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ena_q <= '0;
    else if (full_wr) ena_q <= wdata_i;
  end

  assign ena_o = ena_q;

  p_partial_ignored_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !(&be_i)) |=> $stable(ena_q));
endmodule

// File: rtl/cirq_flag_bank.sv
module cirq_flag_bank #(
  parameter int unsigned NCH   = cirq_pkg::CIRQ_NCH,
  localparam int unsigned LW    = cirq_pkg::CIRQ_LANE,
  localparam int unsigned LANES = NCH / LW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NCH-1:0]   set_i,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic [LANES-1:0] be_i,
  input  logic [NCH-1:0]   wdata_i,
  output logic [NCH-1:0]   flag_o
);
  logic [NCH-1:0] flag_q, seen_q, clr, seen_d;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic hit;
    assign hit = wr_i && be_i[l];
    // clear only bits seen set by the last read and written as zero
    assign clr[l*LW +: LW] = hit ? (seen_q[l*LW +: LW] & ~wdata_i[l*LW +: LW]) : '0;
    always_comb begin
      if (rd_i)     seen_d[l*LW +: LW] = flag_q[l*LW +: LW];
      else if (hit) seen_d[l*LW +: LW] = '0;
      else          seen_d[l*LW +: LW] = seen_q[l*LW +: LW];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= '0;
      seen_q <= '0;
    end else begin
      flag_q <= (flag_q & ~clr) | set_i;
      seen_q <= seen_d;
    end
  end

  assign flag_o = flag_q;

  p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((flag_q & $past(set_i)) == $past(set_i)));
  p_no_host_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(set_i)) == '0));
  p_clear_needs_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((~flag_q & $past(flag_q) & ~$past(seen_q)) == '0));
endmodule

// File: rtl/cirq_req_gen.sv
module cirq_req_gen #(
  parameter int unsigned NCH   = cirq_pkg::CIRQ_NCH,
  parameter int unsigned LVL_W = cirq_pkg::CIRQ_LVL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NCH-1:0]   flag_i,
  input  logic [NCH-1:0]   ena_i,
  input  logic [LVL_W-1:0] lvl_i,
  output logic             irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= (|(flag_i & ena_i)) && (|lvl_i);
  end

  assign irq_o = irq_q;

  p_lvl_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_i == '0) |=> !irq_o);
  p_req_follows_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|(flag_i & ena_i)) && (lvl_i != '0)) |=> irq_o);
  p_masked_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flag_i & ena_i) == '0) |=> !irq_o);
endmodule

// File: rtl/chan_irq_ctrl.sv
module chan_irq_ctrl #(
  parameter int unsigned NCH   = cirq_pkg::CIRQ_NCH,
  parameter int unsigned LVL_W = cirq_pkg::CIRQ_LVL_W,
  localparam int unsigned LANES = NCH / cirq_pkg::CIRQ_LANE
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NCH-1:0]   ch_set_i,
  input  logic             bus_req_i,
  input  logic             bus_we_i,
  input  logic             bus_addr_i,
  input  logic [LANES-1:0] bus_be_i,
  input  logic [NCH-1:0]   bus_wdata_i,
  output logic [NCH-1:0]   bus_rdata_o,
  input  logic [LVL_W-1:0] irq_lvl_i,
  output logic             irq_o
);
  import cirq_pkg::*;

  reg_sel_e       sel;
  logic           ena_wr, flag_wr, flag_rd;
  logic [NCH-1:0] ena, flag;

  assign sel     = reg_sel_e'(bus_addr_i);
  assign ena_wr  = bus_req_i &&  bus_we_i && (sel == SEL_ENA);
  assign flag_wr = bus_req_i &&  bus_we_i && (sel == SEL_FLAG);
  assign flag_rd = bus_req_i && !bus_we_i && (sel == SEL_FLAG);

  cirq_enable_reg #(.NCH(NCH)) u_ena (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (ena_wr),
    .be_i    (bus_be_i),
    .wdata_i (bus_wdata_i),
    .ena_o   (ena)
  );

  cirq_flag_bank #(.NCH(NCH)) u_flag (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (ch_set_i),
    .rd_i    (flag_rd),
    .wr_i    (flag_wr),
    .be_i    (bus_be_i),
    .wdata_i (bus_wdata_i),
    .flag_o  (flag)
  );

  cirq_req_gen #(.NCH(NCH), .LVL_W(LVL_W)) u_req (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flag_i (flag),
    .ena_i  (ena),
    .lvl_i  (irq_lvl_i),
    .irq_o  (irq_o)
  );

  assign bus_rdata_o = (sel == SEL_FLAG) ? flag : ena;
endmodule

// File: tb/sim_chan_irq_ctrl.sv
module sim_chan_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] ch_set = '0;
  logic        req = 1'b0, we = 1'b0, addr = 1'b0;
  logic [1:0]  be = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [2:0]  lvl = '0;
  logic        irq;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  chan_irq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .ch_set_i(ch_set),
    .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr), .bus_be_i(be),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_lvl_i(lvl), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [1:0] b, input logic [15:0] d,
                    input logic [15:0] s = 16'h0);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; be = b; wdata = d; ch_set = s;
    @(posedge clk); #1;
    req = 1'b0; we = 1'b0; be = '0; ch_set = '0;
  endtask

  task automatic rd(input logic a, output logic [15:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a; be = 2'b11;
    #1 d = rdata;
    @(posedge clk); #1;
    req = 1'b0; be = '0;
  endtask

  task automatic pulse(input logic [15:0] s);
    @(negedge clk);
    ch_set = s;
    @(posedge clk); #1;
    ch_set = '0;
  endtask

  task automatic t_reset;
    logic [15:0] d;
    rd(1'b1, d); chk("R1 flags after reset", d, 16'h0);
    rd(1'b0, d); chk("R1 enables after reset", d, 16'h0);
    @(negedge clk); chk("R1 irq after reset", {15'h0, irq}, 16'h0);
  endtask

  task automatic t_set_and_masked;
    logic [15:0] d;
    lvl = 3'd3;
    pulse(16'h0008);
    rd(1'b1, d); chk("R2 R11 flag 3 set", d, 16'h0008);
    @(negedge clk); chk("R5 disabled channel no irq", {15'h0, irq}, 16'h0);
  endtask

  task automatic t_enable;
    logic [15:0] d;
    wr(1'b0, 2'b11, 16'h0008);
    @(negedge clk); chk("R3 irq not yet high", {15'h0, irq}, 16'h0);
    @(negedge clk); chk("R3 irq high one clock later", {15'h0, irq}, 16'h1);
    rd(1'b0, d); chk("R11 enable readback", d, 16'h0008);
    wr(1'b0, 2'b01, 16'h0000);
    rd(1'b0, d); chk("R10 partial enable write ignored", d, 16'h0008);
    @(negedge clk); chk("R10 irq kept", {15'h0, irq}, 16'h1);
  endtask

  task automatic t_level;
    @(negedge clk); lvl = 3'd0;
    @(negedge clk); chk("R4 zero level masks irq", {15'h0, irq}, 16'h0);
    lvl = 3'd5;
    @(negedge clk); chk("R4 nonzero level restores irq", {15'h0, irq}, 16'h1);
  endtask

  task automatic t_disable;
    wr(1'b0, 2'b11, 16'h0000);
    @(negedge clk); @(negedge clk);
    chk("R5 cleared enable drops irq", {15'h0, irq}, 16'h0);
    wr(1'b0, 2'b11, 16'h0008);
  endtask

  task automatic t_clear_protocol;
    logic [15:0] d;
    rd(1'b1, d);
    pulse(16'h0020);
    wr(1'b1, 2'b11, 16'h0000);
    rd(1'b1, d); chk("R6 only flag seen by read cleared", d, 16'h0020);
    wr(1'b1, 2'b11, 16'h0000);
    pulse(16'h0020);
    wr(1'b1, 2'b11, 16'h0000);
    rd(1'b1, d); chk("R12 record used up, re-set flag stays", d, 16'h0020);
    wr(1'b1, 2'b11, 16'h0000);
    rd(1'b1, d); chk("R6 read then zero write clears", d, 16'h0000);
    @(negedge clk); @(negedge clk);
    chk("R3 irq low once flags clear", {15'h0, irq}, 16'h0);
  endtask

  task automatic t_ones;
    logic [15:0] d;
    rd(1'b1, d);
    wr(1'b1, 2'b11, 16'hFFFF);
    rd(1'b1, d); chk("R7 ones write sets nothing", d, 16'h0000);
    @(negedge clk); chk("R7 no irq from host write", {15'h0, irq}, 16'h0);
  endtask

  task automatic t_lanes;
    logic [15:0] d;
    pulse(16'h0202);
    rd(1'b1, d); chk("R2 two flags set", d, 16'h0202);
    wr(1'b1, 2'b01, 16'h0000);
    rd(1'b1, d); chk("R9 low lane only cleared", d, 16'h0200);
    wr(1'b1, 2'b10, 16'h0000);
    rd(1'b1, d); chk("R9 high lane cleared", d, 16'h0000);
  endtask

  task automatic t_race;
    logic [15:0] d;
    pulse(16'h0010);
    rd(1'b1, d);
    wr(1'b1, 2'b11, 16'h0000, 16'h0010);
    rd(1'b1, d); chk("R8 set wins over clear", d, 16'h0010);
    wr(1'b1, 2'b11, 16'h0000);
    rd(1'b1, d); chk("R8 later clear works", d, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_set_and_masked();
    t_enable();
    t_level();
    t_disable();
    t_clear_protocol();
    t_ones();
    t_lanes();
    t_race();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule